// File: doc/BRIEF.md
# Windowed Register Index Mapper

This block turns an architectural integer register number into an index into a flat physical register file. The machine it serves has overlapping register windows and several banks of global registers. The block holds two pieces of state: the current window pointer and the global bank level. From them it builds three translation views. The current view uses the pointer as it stands. The next view uses the window one below it. The previous view uses the window one above it. All three views share the same global bank.

A single write port sets either the window pointer or the global level. Out-of-range values saturate. The change becomes visible one cycle after the write. A combinational lookup port takes a view code and an architectural number and returns the physical index together with a hit flag. A few microcode scratch registers sit after all the windowed storage. They are translated the same way in every view.

The physical file is laid out as follows. First come the global banks, (MAX_GL+1)×8 entries in total. Next comes the windowed region, NWIN×16 entries. The microcode registers come last.

Top module: `wreg_index_map`

## Requirements
- R1: Architectural number 0 (global zero) maps to physical index 0 in every view and for every global level.
- R2: Architectural numbers 1 to 7 map to physical index a + GL×8, where GL is the current global level.
- R3: Architectural numbers 8 to 31 are windowed slots s = a − 8. In view code 0 (current) such a slot maps to TG + ((s − CWP×16) mod NWIN×16), where TG = (MAX_GL+1)×8.
- R4: View code 1 (next) applies the R3 formula with window CWP−1 taken modulo NWIN, so at CWP = 0 it uses window NWIN−1. View code 2 (previous) uses CWP+1 modulo NWIN, so at CWP = NWIN−1 it uses window 0. All views use the same GL.
- R5: Architectural numbers 32 to 32+NUM_MICRO−1 map to TG + NWIN×16 + (a − 32) in views 0, 1 and 2.
- R6: For view code 3, or for an architectural number of 32+NUM_MICRO or above, lk_hit is 0 and lk_idx is 0. Otherwise lk_hit is 1.
- R7: A write with wr_sel = 0 sets CWP to wr_data, or to NWIN−1 when wr_data ≥ NWIN. The new value is seen on cwp_o and in all views from the cycle after the write edge.
- R8: A write with wr_sel = 1 sets GL to wr_data, or to MAX_GL when wr_data > MAX_GL. The new value is seen on gl_o and in the globals of all views from the cycle after the write edge.
- R9: After reset, CWP = 0 and GL = 0, and all views translate from those values.
- R10: A write to one field leaves the other field unchanged. With wr_en low, neither field changes, whatever wr_data holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the pointer state |
| wr_sel | input | 1 | 0 selects the window pointer, 1 selects the global level |
| wr_data | input | WR_W | Value to write |
| lk_view | input | 2 | View code: 0 current, 1 next, 2 previous, 3 none |
| lk_arch | input | ARCH_W | Architectural register number |
| lk_idx | output | PHYS_W | Physical register index |
| lk_hit | output | 1 | Lookup maps to a real register |
| cwp_o | output | CWP_W | Current window pointer |
| gl_o | output | GL_W | Current global level |

## Verification
The bench goes after the wrap cases of the window views. At CWP = 0 the next view must land on window NWIN−1. A mapper that subtracted without a modulo would produce an index below the windowed region or inside the globals. At CWP = NWIN−1 the previous view must fold back to window 0. A mapper that failed to fold would index the microcode area.

Writes above the limits are issued for both fields. A wrapping design would show a small pointer where NWIN−1 is expected, and an unclamped level would send globals into the windowed region.

Global zero is swept at every level. A mapper that banked it would return 8×GL instead of 0. View code 3 and numbers past the microcode range are swept to catch a design that reports a hit for a register that does not exist.

// File: rtl/wim_pkg.sv
package wim_pkg;
   localparam int GLOB_PER_BANK = 8;
   localparam int REGS_PER_WIN  = 16;
   localparam int WIN_SLOTS     = 24;
   localparam int WIN_ARCH_BASE = 8;
   localparam int MICRO_ARCH_BASE = WIN_ARCH_BASE + WIN_SLOTS;
   localparam int NUM_VIEWS     = 3;

   typedef enum logic [1:0] {
      VIEW_CUR  = 2'd0,
      VIEW_NXT  = 2'd1,
      VIEW_PRV  = 2'd2,
      VIEW_NONE = 2'd3
   } view_e;

   typedef enum logic {
      WSEL_CWP = 1'b0,
      WSEL_GL  = 1'b1
   } wsel_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/wim_ptr_regs.sv
module wim_ptr_regs
   import wim_pkg::*;
#(
   parameter int NWIN   = 8,
   parameter int MAX_GL = 3,
   parameter int WR_W   = 8,
   localparam int CWP_W = $clog2(NWIN),
   localparam int GL_W  = $clog2(MAX_GL + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [WR_W-1:0]  wr_data,
   output logic [CWP_W-1:0] cwp_q,
   output logic [GL_W-1:0]  gl_q,
   output logic [CWP_W-1:0] ptr_nxt,
   output logic [CWP_W-1:0] ptr_prv
);
   localparam bit POW2 = is_pow2(NWIN);

   logic [CWP_W-1:0] cwp_wr, nxt_d, prv_d;
   logic [GL_W-1:0]  gl_wr;

   // saturating decode of the written value
   always_comb begin
      if (int'(wr_data) >= NWIN) cwp_wr = CWP_W'(NWIN - 1);
      else                       cwp_wr = CWP_W'(wr_data);
      if (int'(wr_data) > MAX_GL) gl_wr = GL_W'(MAX_GL);
      else                        gl_wr = GL_W'(wr_data);
   end

   // neighbour windows: natural wrap for a power-of-two ring, compare otherwise
   generate
      if (POW2) begin : g_ring_pow2
         assign nxt_d = cwp_wr - CWP_W'(1);
         assign prv_d = cwp_wr + CWP_W'(1);
      end else begin : g_ring_cmp
         assign nxt_d = (cwp_wr == '0) ? CWP_W'(NWIN - 1) : cwp_wr - CWP_W'(1);
         assign prv_d = (cwp_wr == CWP_W'(NWIN - 1)) ? '0 : cwp_wr + CWP_W'(1);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cwp_q   <= '0;
         gl_q    <= '0;
         ptr_nxt <= CWP_W'(NWIN - 1);
         ptr_prv <= CWP_W'(1);
      end else if (wr_en) begin
         if (wr_sel == WSEL_CWP) begin
            cwp_q   <= cwp_wr;
            ptr_nxt <= nxt_d;
            ptr_prv <= prv_d;
         end else begin
            gl_q <= gl_wr;
         end
      end
   end

   AST_CWP_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == WSEL_CWP && int'(wr_data) >= NWIN) |=> (int'(cwp_q) == NWIN - 1)); // R7
   AST_GL_SAT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == WSEL_GL && int'(wr_data) > MAX_GL) |=> (int'(gl_q) == MAX_GL)); // R8
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> ($stable(cwp_q) && $stable(gl_q))); // R10
   AST_GL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == WSEL_CWP) |=> $stable(gl_q)); // R10
   AST_CWP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(cwp_q) < NWIN); // R7
   AST_VIEW_RING: assert property (@(posedge clk) disable iff (!rst_n)
      ((int'(ptr_nxt) + 1) % NWIN == int'(cwp_q)) && ((int'(cwp_q) + 1) % NWIN == int'(ptr_prv))); // R4
endmodule

// File: rtl/wim_view_xlate.sv
module wim_view_xlate
   import wim_pkg::*;
#(
   parameter int NWIN    = 8,
   localparam int CWP_W  = $clog2(NWIN),
   localparam int TW     = NWIN * REGS_PER_WIN,
   localparam int WOFF_W = $clog2(TW),
   localparam int SUM_W  = $clog2(TW + WIN_SLOTS) + 1
) (
   input  logic [CWP_W-1:0]  win_ptr,
   input  logic [4:0]        slot,
   output logic [WOFF_W-1:0] woff
);
   logic [SUM_W-1:0] raw;

   // slot + TW - ptr*16 lies in [16, 2*TW) because ptr <= NWIN-1 and slot < 24
   assign raw = SUM_W'(slot) + SUM_W'(TW) - (SUM_W'(win_ptr) << 4);

   generate
      if (is_pow2(NWIN)) begin : g_wrap_mask
         assign woff = WOFF_W'(raw);
      end else begin : g_wrap_sub
         always_comb begin
            if (raw >= SUM_W'(TW)) woff = WOFF_W'(raw - SUM_W'(TW));
            else                   woff = WOFF_W'(raw);
         end
      end
   endgenerate
endmodule

// File: rtl/wreg_index_map.sv
module wreg_index_map
   import wim_pkg::*;
#(
   parameter int NWIN      = 8,
   parameter int MAX_GL    = 3,
   parameter int NUM_MICRO = 8,
   parameter int WR_W      = 8,
   localparam int CWP_W    = $clog2(NWIN),
   localparam int GL_W     = $clog2(MAX_GL + 1),
   localparam int TG       = (MAX_GL + 1) * GLOB_PER_BANK,
   localparam int TW       = NWIN * REGS_PER_WIN,
   localparam int PHYS     = TG + TW + NUM_MICRO,
   localparam int PHYS_W   = $clog2(PHYS),
   localparam int ARCH_SPAN = MICRO_ARCH_BASE + NUM_MICRO,
   localparam int ARCH_W   = $clog2(ARCH_SPAN),
   localparam int WOFF_W   = $clog2(TW)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_sel,
   input  logic [WR_W-1:0]   wr_data,
   input  logic [1:0]        lk_view,
   input  logic [ARCH_W-1:0] lk_arch,
   output logic [PHYS_W-1:0] lk_idx,
   output logic              lk_hit,
   output logic [CWP_W-1:0]  cwp_o,
   output logic [GL_W-1:0]   gl_o
);
   initial begin
      assert (NWIN >= 2) else $error("NWIN must be at least 2");
      assert (MAX_GL >= 1) else $error("MAX_GL must be at least 1");
      assert (NUM_MICRO >= 1) else $error("NUM_MICRO must be at least 1");
      assert (WR_W >= CWP_W && WR_W >= GL_W && WR_W <= 31) else $error("WR_W out of range");
   end

   logic [CWP_W-1:0]  cwp_q, ptr_nxt, ptr_prv;
   logic [GL_W-1:0]   gl_q;
   logic [CWP_W-1:0]  vptr [NUM_VIEWS];
   logic [WOFF_W-1:0] woff [NUM_VIEWS];
   logic [WOFF_W-1:0] woff_sel;
   logic [4:0]        slot;
   int                a;

   wim_ptr_regs #(.NWIN(NWIN), .MAX_GL(MAX_GL), .WR_W(WR_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .cwp_q   (cwp_q),
      .gl_q    (gl_q),
      .ptr_nxt (ptr_nxt),
      .ptr_prv (ptr_prv)
   );

   assign vptr[0] = cwp_q;
   assign vptr[1] = ptr_nxt;
   assign vptr[2] = ptr_prv;
   assign a       = int'(lk_arch);
   assign slot    = 5'(a - WIN_ARCH_BASE);

   generate
      for (genvar v = 0; v < NUM_VIEWS; v++) begin : g_view
         wim_view_xlate #(.NWIN(NWIN)) u_xlate (
            .win_ptr (vptr[v]),
            .slot    (slot),
            .woff    (woff[v])
         );
      end
   endgenerate

   always_comb begin
      case (lk_view)
         VIEW_NXT: woff_sel = woff[1];
         VIEW_PRV: woff_sel = woff[2];
         default:  woff_sel = woff[0];
      endcase
   end

   always_comb begin
      lk_idx = '0;
      lk_hit = 1'b0;
      if (lk_view != VIEW_NONE && a < ARCH_SPAN) begin
         lk_hit = 1'b1;
         if (a == 0)
            lk_idx = '0;
         else if (a < WIN_ARCH_BASE)
            lk_idx = PHYS_W'(a + int'(gl_q) * GLOB_PER_BANK);
         else if (a < MICRO_ARCH_BASE)
            lk_idx = PHYS_W'(TG + int'(woff_sel));
         else
            lk_idx = PHYS_W'(TG + TW + a - MICRO_ARCH_BASE);
      end
   end

   assign cwp_o = cwp_q;
   assign gl_o  = gl_q;

   AST_G0_PINNED: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && lk_arch == '0) |-> (lk_idx == '0)); // R1
   AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (int'(lk_idx) < PHYS)); // R6
   AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_idx == '0)); // R6
   AST_WIN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && a >= WIN_ARCH_BASE && a < MICRO_ARCH_BASE)
         |-> (int'(lk_idx) >= TG && int'(lk_idx) < TG + TW)); // R3
   AST_RESET_STATE: assert property (@(posedge clk)
      $rose(rst_n) |-> (cwp_o == '0 && gl_o == '0)); // R9
endmodule

// File: tb/wreg_index_map_bench.sv
`timescale 1ns/1ps
module wreg_index_map_bench;
   localparam int NWIN = 8;
   localparam int MAX_GL = 3;
   localparam int NUM_MICRO = 8;
   localparam int WR_W = 8;
   localparam int TG = (MAX_GL + 1) * 8;
   localparam int TW = NWIN * 16;
   localparam int SPAN = 32 + NUM_MICRO;

   typedef struct {
      int    sel;   // 0 idx, 1 hit, 2 cwp, 3 gl
      int    exp;
      string tag;
   } sb_item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic wr_sel = 1'b0;
   logic [WR_W-1:0] wr_data = '0;
   logic [1:0] lk_view = '0;
   logic [5:0] lk_arch = '0;
   logic [7:0] lk_idx;
   logic lk_hit;
   logic [2:0] cwp_o;
   logic [1:0] gl_o;

   int checks = 0;
   int errors = 0;
   int m_cwp = 0;
   int m_gl = 0;
   bit done = 1'b0;
   sb_item_t sbq[$];

   always #2.5 clk = ~clk;

   wreg_index_map #(.NWIN(NWIN), .MAX_GL(MAX_GL), .NUM_MICRO(NUM_MICRO), .WR_W(WR_W))
   u_wreg_index_map (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .lk_view(lk_view), .lk_arch(lk_arch), .lk_idx(lk_idx), .lk_hit(lk_hit),
      .cwp_o(cwp_o), .gl_o(gl_o)
   );

   function automatic int model_hit(int view, int a);
      return (view != 3 && a < SPAN) ? 1 : 0;
   endfunction

   function automatic int model_idx(int view, int a, int cwp, int gl);
      int w, t;
      if (model_hit(view, a) == 0) return 0;
      if (a == 0) return 0;
      if (a < 8) return a + gl * 8;
      if (a < 32) begin
         w = cwp + ((view == 1) ? -1 : (view == 2) ? 1 : 0);
         t = ((a - 8) - w * 16) % TW;
         if (t < 0) t += TW;
         return TG + t;
      end
      return TG + TW + a - 32;
   endfunction

   function automatic string tag_for(int view, int a);
      if (view == 3 || a >= SPAN) return "R6";
      if (a == 0) return "R1";
      if (a < 8) return "R2";
      if (a < 32) return (view == 0) ? "R3" : "R4";
      return "R5";
   endfunction

   function automatic void push(int sel, int exp, string tag);
      sb_item_t it;
      it.sel = sel; it.exp = exp; it.tag = tag;
      sbq.push_back(it);
   endfunction

   // monitor: drains expectations while the driven inputs are stable
   initial begin
      forever begin
         @(negedge clk);
         #2;
         while (sbq.size() > 0) begin
            sb_item_t it;
            int got;
            it = sbq.pop_front();
            case (it.sel)
               0: got = int'(lk_idx);
               1: got = int'(lk_hit);
               2: got = int'(cwp_o);
               default: got = int'(gl_o);
            endcase
            checks++;
            if (got != it.exp) begin
               errors++;
               $display("FAIL %s field=%0d view=%0d arch=%0d actual=%0d expected=%0d",
                        it.tag, it.sel, lk_view, lk_arch, got, it.exp);
            end
         end
      end
   end

   task automatic check_state(string tag);
      push(2, m_cwp, tag);
      push(3, m_gl, tag);
   endtask

   task automatic lookup(int view, int a);
      @(negedge clk);
      lk_view = 2'(view);
      lk_arch = 6'(a);
      #1;
      push(0, model_idx(view, a, m_cwp, m_gl), tag_for(view, a));
      push(1, model_hit(view, a), tag_for(view, a));
   endtask

   task automatic sweep();
      for (int v = 0; v < 4; v++)
         for (int a = 0; a < 64; a++)
            lookup(v, a);
   endtask

   task automatic do_write(int sel, int data, string tag);
      @(negedge clk);
      wr_en = 1'b1;
      wr_sel = sel[0];
      wr_data = WR_W'(data);
      @(negedge clk);
      wr_en = 1'b0;
      wr_data = 8'hA5;
      if (sel == 0) m_cwp = (data >= NWIN) ? NWIN - 1 : data;
      else          m_gl  = (data > MAX_GL) ? MAX_GL : data;
      #1;
      check_state(tag);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      check_state("R9");
      sweep();                            // R9 views from reset, R4 wrap at CWP=0
      do_write(1, 2, "R8");               // R10 cwp kept
      sweep();
      do_write(0, 5, "R7");               // R10 gl kept
      sweep();
      do_write(0, 200, "R7");             // clamp to NWIN-1, R4 wrap of previous view
      sweep();
      do_write(1, 9, "R8");               // clamp to MAX_GL
      sweep();
      do_write(0, NWIN, "R7");            // first clamped value
      do_write(0, NWIN - 1, "R7");        // largest legal value
      for (int k = 0; k < 4; k++) begin   // R10 idle cycles with junk data
         @(negedge clk);
         wr_sel = k[0];
         wr_data = 8'hFF;
         #1;
         check_state("R10");
      end
      do_write(0, 0, "R7");
      do_write(1, 0, "R8");
      sweep();
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule